// File: doc/BRIEF.md
# Programmable User Pulse Generator

This block derives a set of user-defined timing strobes from a running raster timing generator. The timing generator supplies the current pixel position within the line and the current line position within the frame. Both count from zero at the leading edge of horizontal and vertical sync. For each strobe, software chooses a horizontal pixel window and a vertical line window, and the strobe is high where the two overlap. A typical strobe is a back-porch marker that appears only on active lines.

Each strobe can also be merged with the window of the next strobe, which gives composite shapes. Examples are the active part of a chosen band of lines, or a notch cut out of a larger region. A polarity bit then inverts the result if required. Software writes the configuration through a simple parallel write port into staging registers. These are copied into the working set only at a frame boundary, so a frame never shows half of an update.

Top module: `user_pulse_gen`

## Requirements
- R1: After reset all working and staging settings are zero, so every window is empty and `pulse_o` is all zeros.
- R2: The horizontal window of strobe n is true when hstart <= `h_cnt_i` < hstop, using unsigned compares.
- R3: The vertical window of strobe n is true when vstart <= `v_cnt_i` < vstop. The window of strobe n is the AND of its horizontal and vertical windows.
- R4: A window whose start is equal to or greater than its stop is empty for every count.
- R5: Control bit 0 of strobe n inverts its output after the combine stage.
- R6: Control bits [2:1] of strobe n select how its window combines with the window of strobe (n+1) mod N. The codes are 0 = own window only, 1 = AND, 2 = OR, 3 = XOR. The last strobe pairs with strobe 0.
- R7: Writes land in staging registers and have no effect on `pulse_o` until a cycle with `frame_start_i` high. The new settings govern the output from the following cycle on.
- R8: The write address is {strobe index, field[2:0]}. The field codes are 0 = hstart, 1 = hstop, 2 = vstart, 3 = vstop, 4 = control. Field codes 5 to 7 change nothing.
- R9: `pulse_o` is registered: it reflects the counts and settings sampled at the previous rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_start_i | input | 1 | Frame boundary strobe; copies staged settings into the working set |
| h_cnt_i | input | H_W | Pixel count from the leading edge of H sync |
| v_cnt_i | input | V_W | Line count from the leading edge of V sync |
| wr_en_i | input | 1 | Register write enable |
| wr_addr_i | input | $clog2(N_OUT)+3 | Write address {strobe index, field} |
| wr_data_i | input | DATA_W | Write data |
| pulse_o | output | N_OUT | User strobes |

## Verification
The bench targets the window edges: the first pixel or line inside a window, and the stop position itself. A design that compares inclusively on either side would then show a strobe one pixel or one line too long or too short. It also targets degenerate and reversed windows, where a design that wraps the compare would light a strobe across the whole frame. It checks that the last strobe combines with strobe 0, which a design that pairs with the wrong neighbour or leaves the last combine open would get wrong. It also checks writes between frame boundaries and to unused field codes. A design without shadowing, or with loose address decoding, would change the output mid-frame or corrupt another setting.

// File: rtl/upg_pkg.sv
package upg_pkg;
  typedef enum logic [1:0] {
    CMB_NONE = 2'd0,
    CMB_AND  = 2'd1,
    CMB_OR   = 2'd2,
    CMB_XOR  = 2'd3
  } cmb_mode_e;

  localparam int FLD_W = 3;
  localparam logic [FLD_W-1:0] FLD_HSTART = 3'd0;
  localparam logic [FLD_W-1:0] FLD_HSTOP  = 3'd1;
  localparam logic [FLD_W-1:0] FLD_VSTART = 3'd2;
  localparam logic [FLD_W-1:0] FLD_VSTOP  = 3'd3;
  localparam logic [FLD_W-1:0] FLD_CTRL   = 3'd4;
endpackage

// File: rtl/upg_regs.sv
module upg_regs
  import upg_pkg::*;
#(
  parameter int N_OUT  = 4,
  parameter int H_W    = 12,
  parameter int V_W    = 12,
  parameter int DATA_W = 12,
  parameter int ADDR_W = 5
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        frame_start_i,
  input  logic                        wr_en_i,
  input  logic [ADDR_W-1:0]           wr_addr_i,
  input  logic [DATA_W-1:0]           wr_data_i,
  output logic [N_OUT-1:0][H_W-1:0]   stg_hs_o,
  output logic [N_OUT-1:0][H_W-1:0]   stg_he_o,
  output logic [N_OUT-1:0][V_W-1:0]   stg_vs_o,
  output logic [N_OUT-1:0][V_W-1:0]   stg_ve_o,
  output logic [N_OUT-1:0]            stg_pol_o,
  output logic [N_OUT-1:0][1:0]       stg_mode_o,
  output logic [N_OUT-1:0][H_W-1:0]   act_hs_o,
  output logic [N_OUT-1:0][H_W-1:0]   act_he_o,
  output logic [N_OUT-1:0][V_W-1:0]   act_vs_o,
  output logic [N_OUT-1:0][V_W-1:0]   act_ve_o,
  output logic [N_OUT-1:0]            act_pol_o,
  output logic [N_OUT-1:0][1:0]       act_mode_o
);
  localparam int IDX_W = ADDR_W - FLD_W;

  logic [IDX_W-1:0] wr_idx;
  logic [FLD_W-1:0] wr_fld;
  assign wr_idx = wr_addr_i[ADDR_W-1:FLD_W];
  assign wr_fld = wr_addr_i[FLD_W-1:0];

  for (genvar g = 0; g < N_OUT; g++) begin : g_ch
    logic sel;
    assign sel = wr_en_i && (wr_idx == IDX_W'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        stg_hs_o[g]   <= '0;
        stg_he_o[g]   <= '0;
        stg_vs_o[g]   <= '0;
        stg_ve_o[g]   <= '0;
        stg_pol_o[g]  <= 1'b0;
        stg_mode_o[g] <= '0;
      end else if (sel) begin
        case (wr_fld)
          FLD_HSTART: stg_hs_o[g] <= wr_data_i[H_W-1:0];
          FLD_HSTOP:  stg_he_o[g] <= wr_data_i[H_W-1:0];
          FLD_VSTART: stg_vs_o[g] <= wr_data_i[V_W-1:0];
          FLD_VSTOP:  stg_ve_o[g] <= wr_data_i[V_W-1:0];
          FLD_CTRL: begin
            stg_pol_o[g]  <= wr_data_i[0];
            stg_mode_o[g] <= wr_data_i[2:1];
          end
          default: ;
        endcase
      end
    end

    // working set only moves at the frame boundary
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        act_hs_o[g]   <= '0;
        act_he_o[g]   <= '0;
        act_vs_o[g]   <= '0;
        act_ve_o[g]   <= '0;
        act_pol_o[g]  <= 1'b0;
        act_mode_o[g] <= '0;
      end else if (frame_start_i) begin
        act_hs_o[g]   <= stg_hs_o[g];
        act_he_o[g]   <= stg_he_o[g];
        act_vs_o[g]   <= stg_vs_o[g];
        act_ve_o[g]   <= stg_ve_o[g];
        act_pol_o[g]  <= stg_pol_o[g];
        act_mode_o[g] <= stg_mode_o[g];
      end
    end
  end
endmodule

// File: rtl/upg_window.sv
module upg_window #(
  parameter int H_W = 12,
  parameter int V_W = 12
) (
  input  logic [H_W-1:0] h_cnt_i,
  input  logic [V_W-1:0] v_cnt_i,
  input  logic [H_W-1:0] hs_i,
  input  logic [H_W-1:0] he_i,
  input  logic [V_W-1:0] vs_i,
  input  logic [V_W-1:0] ve_i,
  output logic           win_o
);
  logic h_in, v_in;
  // half-open intervals: start == stop gives an empty window
  assign h_in  = (h_cnt_i >= hs_i) && (h_cnt_i < he_i);
  assign v_in  = (v_cnt_i >= vs_i) && (v_cnt_i < ve_i);
  assign win_o = h_in && v_in;
endmodule

// File: rtl/upg_combine.sv
module upg_combine
  import upg_pkg::*;
#(
  parameter int N_OUT = 4
) (
  input  logic [N_OUT-1:0]      win_i,
  input  logic [N_OUT-1:0][1:0] mode_i,
  input  logic [N_OUT-1:0]      pol_i,
  output logic [N_OUT-1:0]      pulse_o
);
  for (genvar g = 0; g < N_OUT; g++) begin : g_cmb
    localparam int NXT = (g + 1) % N_OUT;
    logic raw;
    always_comb begin
      case (cmb_mode_e'(mode_i[g]))
        CMB_AND: raw = win_i[g] & win_i[NXT];
        CMB_OR:  raw = win_i[g] | win_i[NXT];
        CMB_XOR: raw = win_i[g] ^ win_i[NXT];
        default: raw = win_i[g];
      endcase
    end
    assign pulse_o[g] = raw ^ pol_i[g];
  end
endmodule

// File: rtl/user_pulse_gen.sv
module user_pulse_gen #(
  parameter int N_OUT  = 4,
  parameter int H_W    = 12,
  parameter int V_W    = 12,
  parameter int DATA_W = 12,
  localparam int ADDR_W = $clog2(N_OUT) + upg_pkg::FLD_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              frame_start_i,
  input  logic [H_W-1:0]    h_cnt_i,
  input  logic [V_W-1:0]    v_cnt_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [N_OUT-1:0]  pulse_o
);
  logic [N_OUT-1:0][H_W-1:0] stg_hs, stg_he, act_hs, act_he;
  logic [N_OUT-1:0][V_W-1:0] stg_vs, stg_ve, act_vs, act_ve;
  logic [N_OUT-1:0]          stg_pol, act_pol;
  logic [N_OUT-1:0][1:0]     stg_mode, act_mode;
  logic [N_OUT-1:0]          win, pulse_d;

  upg_regs #(
    .N_OUT(N_OUT), .H_W(H_W), .V_W(V_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
  ) u_regs (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .frame_start_i(frame_start_i),
    .wr_en_i      (wr_en_i),
    .wr_addr_i    (wr_addr_i),
    .wr_data_i    (wr_data_i),
    .stg_hs_o     (stg_hs),
    .stg_he_o     (stg_he),
    .stg_vs_o     (stg_vs),
    .stg_ve_o     (stg_ve),
    .stg_pol_o    (stg_pol),
    .stg_mode_o   (stg_mode),
    .act_hs_o     (act_hs),
    .act_he_o     (act_he),
    .act_vs_o     (act_vs),
    .act_ve_o     (act_ve),
    .act_pol_o    (act_pol),
    .act_mode_o   (act_mode)
  );

  for (genvar g = 0; g < N_OUT; g++) begin : g_win
    upg_window #(.H_W(H_W), .V_W(V_W)) u_win (
      .h_cnt_i(h_cnt_i),
      .v_cnt_i(v_cnt_i),
      .hs_i   (act_hs[g]),
      .he_i   (act_he[g]),
      .vs_i   (act_vs[g]),
      .ve_i   (act_ve[g]),
      .win_o  (win[g])
    );
  end

  upg_combine #(.N_OUT(N_OUT)) u_cmb (
    .win_i  (win),
    .mode_i (act_mode),
    .pol_i  (act_pol),
    .pulse_o(pulse_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pulse_o <= '0;
    else         pulse_o <= pulse_d;
  end
endmodule

// File: rtl/upg_chk.sv
module upg_chk #(
  parameter int N_OUT  = 4,
  parameter int H_W    = 12,
  parameter int V_W    = 12,
  parameter int ADDR_W = 5
) (
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic                      frame_start_i,
  input logic [V_W-1:0]            v_cnt_i,
  input logic                      wr_en_i,
  input logic [ADDR_W-1:0]         wr_addr_i,
  input logic [N_OUT-1:0]          pulse_o,
  input logic [N_OUT-1:0][H_W-1:0] stg_hs,
  input logic [N_OUT-1:0][H_W-1:0] stg_he,
  input logic [N_OUT-1:0][V_W-1:0] stg_vs,
  input logic [N_OUT-1:0][V_W-1:0] stg_ve,
  input logic [N_OUT-1:0]          stg_pol,
  input logic [N_OUT-1:0][1:0]     stg_mode,
  input logic [N_OUT-1:0][H_W-1:0] act_hs,
  input logic [N_OUT-1:0][H_W-1:0] act_he,
  input logic [N_OUT-1:0][V_W-1:0] act_vs,
  input logic [N_OUT-1:0][V_W-1:0] act_ve,
  input logic [N_OUT-1:0]          act_pol,
  input logic [N_OUT-1:0][1:0]     act_mode
);
  // R7
  act_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_start_i |=> $stable(act_hs) && $stable(act_he) && $stable(act_vs)
                       && $stable(act_ve) && $stable(act_pol) && $stable(act_mode));

  // R7
  act_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_i |=> act_hs == $past(stg_hs) && act_he == $past(stg_he)
                      && act_vs == $past(stg_vs) && act_ve == $past(stg_ve)
                      && act_pol == $past(stg_pol) && act_mode == $past(stg_mode));

  // R8
  bad_field_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i[2:0] > 3'd4) |=> $stable(stg_hs) && $stable(stg_he)
      && $stable(stg_vs) && $stable(stg_ve) && $stable(stg_pol) && $stable(stg_mode));

  for (genvar g = 0; g < N_OUT; g++) begin : g_p
    // R4
    empty_win_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (act_mode[g] == 2'd0 && act_hs[g] >= act_he[g]) |=> pulse_o[g] == $past(act_pol[g]));

    // R3
    v_out_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (act_mode[g] == 2'd0 && !(v_cnt_i >= act_vs[g] && v_cnt_i < act_ve[g]))
        |=> pulse_o[g] == $past(act_pol[g]));
  end
endmodule

bind user_pulse_gen upg_chk #(
  .N_OUT(N_OUT), .H_W(H_W), .V_W(V_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .frame_start_i(frame_start_i),
  .v_cnt_i      (v_cnt_i),
  .wr_en_i      (wr_en_i),
  .wr_addr_i    (wr_addr_i),
  .pulse_o      (pulse_o),
  .stg_hs       (stg_hs),
  .stg_he       (stg_he),
  .stg_vs       (stg_vs),
  .stg_ve       (stg_ve),
  .stg_pol      (stg_pol),
  .stg_mode     (stg_mode),
  .act_hs       (act_hs),
  .act_he       (act_he),
  .act_vs       (act_vs),
  .act_ve       (act_ve),
  .act_pol      (act_pol),
  .act_mode     (act_mode)
);

// File: tb/tb_user_pulse_gen.sv
`timescale 1ns/1ps
module tb_user_pulse_gen;
  localparam int N = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fs = 1'b0;
  logic [11:0] h = '0;
  logic [11:0] v = '0;
  logic        we = 1'b0;
  logic [4:0]  wa = '0;
  logic [11:0] wd = '0;
  logic [3:0]  pulse;

  int n_chk = 0;
  int n_err = 0;
  bit done = 0;

  int s_hs[N], s_he[N], s_vs[N], s_ve[N], s_pol[N], s_md[N];
  int a_hs[N], a_he[N], a_vs[N], a_ve[N], a_pol[N], a_md[N];

  always #10 clk = ~clk;

  user_pulse_gen dut (
    .clk_i(clk), .rst_ni(rst_n), .frame_start_i(fs), .h_cnt_i(h), .v_cnt_i(v),
    .wr_en_i(we), .wr_addr_i(wa), .wr_data_i(wd), .pulse_o(pulse)
  );

  function automatic logic [3:0] expect_out(int hc, int vc);
    logic [3:0] w, r;
    for (int i = 0; i < N; i++)
      w[i] = (hc >= a_hs[i]) && (hc < a_he[i]) && (vc >= a_vs[i]) && (vc < a_ve[i]);
    for (int i = 0; i < N; i++) begin
      int j = (i + 1) % N;
      case (a_md[i])
        1: r[i] = w[i] & w[j];
        2: r[i] = w[i] | w[j];
        3: r[i] = w[i] ^ w[j];
        default: r[i] = w[i];
      endcase
      r[i] = r[i] ^ a_pol[i][0];
    end
    return r;
  endfunction

  task automatic check(string tag, logic [3:0] got, logic [3:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s pulse=%b expected=%b", tag, got, exp);
    end
  endtask

  task automatic wr(int idx, int fld, int data);
    @(negedge clk);
    fs = 1'b0; we = 1'b1; wa = 5'(idx * 8 + fld); wd = 12'(data);
    @(negedge clk);
    we = 1'b0;
    case (fld)
      0: s_hs[idx] = data;
      1: s_he[idx] = data;
      2: s_vs[idx] = data;
      3: s_ve[idx] = data;
      4: begin s_pol[idx] = data & 1; s_md[idx] = (data >> 1) & 3; end
      default: ;
    endcase
  endtask

  task automatic cfg(int idx, int hs0, int he0, int vs0, int ve0, int ctl);
    wr(idx, 0, hs0); wr(idx, 1, he0); wr(idx, 2, vs0); wr(idx, 3, ve0); wr(idx, 4, ctl);
  endtask

  task automatic step(int hc, int vc, bit f, string tag);
    logic [3:0] e;
    @(negedge clk);
    h = 12'(hc); v = 12'(vc); fs = f;
    e = expect_out(hc, vc);
    @(posedge clk);
    #1;
    if (f) begin
      a_hs = s_hs; a_he = s_he; a_vs = s_vs; a_ve = s_ve; a_pol = s_pol; a_md = s_md;
    end
    check(tag, pulse, e);
  endtask

  task automatic load();
    step(0, 0, 1'b1, "R7");
  endtask

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < N; i++) begin
      s_hs[i] = 0; s_he[i] = 0; s_vs[i] = 0; s_ve[i] = 0; s_pol[i] = 0; s_md[i] = 0;
      a_hs[i] = 0; a_he[i] = 0; a_vs[i] = 0; a_ve[i] = 0; a_pol[i] = 0; a_md[i] = 0;
    end
    repeat (3) @(negedge clk);
    check("R1", pulse, 4'b0000);
    rst_n = 1'b1;
    step(0, 0, 1'b0, "R1");
    step(5, 3, 1'b1, "R1");

    // staged but not loaded: R7
    cfg(0, 10, 20, 5, 8, 0);
    step(12, 6, 1'b0, "R7");
    load();
    // R2 edges
    step(12, 6, 1'b0, "R2");
    step(9, 6, 1'b0, "R2");
    step(10, 6, 1'b0, "R2");
    step(20, 6, 1'b0, "R2");
    step(19, 7, 1'b0, "R2");
    // R3 edges
    step(12, 8, 1'b0, "R3");
    step(12, 4, 1'b0, "R3");
    step(12, 5, 1'b0, "R3");

    // R4 start == stop, then start > stop
    cfg(1, 15, 15, 0, 100, 0);
    load();
    step(15, 3, 1'b0, "R4");
    wr(1, 0, 20); wr(1, 1, 10);
    load();
    step(15, 3, 1'b0, "R4");
    step(25, 3, 1'b0, "R4");
    // R5 polarity on empty window
    wr(1, 4, 1);
    load();
    step(15, 3, 1'b0, "R5");

    // R6 modes
    cfg(2, 0, 30, 10, 20, 2);
    cfg(3, 5, 50, 0, 12, 0);
    load();
    step(10, 11, 1'b0, "R6");
    step(10, 15, 1'b0, "R6");
    wr(2, 4, 4); load();
    step(10, 15, 1'b0, "R6");
    step(40, 5, 1'b0, "R6");
    wr(2, 4, 6); load();
    step(10, 11, 1'b0, "R6");
    step(10, 15, 1'b0, "R6");
    // R6 wrap: last strobe pairs with strobe 0
    wr(3, 4, 6); load();
    step(12, 6, 1'b0, "R6");
    step(30, 6, 1'b0, "R6");
    wr(3, 4, 2); load();
    step(30, 6, 1'b0, "R6");

    // R8 unused field codes, then a real field
    wr(0, 5, 12'hFFF); wr(0, 7, 0); load();
    step(12, 6, 1'b0, "R8");
    wr(0, 0, 11); load();
    step(10, 6, 1'b0, "R8");
    step(11, 6, 1'b0, "R8");

    // R9 output follows the previous edge only
    step(0, 0, 1'b0, "R9");
    @(negedge clk);
    h = 12'd12; v = 12'd6;
    #1;
    check("R9", pulse, expect_out(0, 0));
    @(posedge clk);
    #1;
    check("R9", pulse, expect_out(12, 6));

    // random rounds
    for (int r = 0; r < 30; r++) begin
      for (int i = 0; i < N; i++)
        cfg(i, $urandom_range(0, 40), $urandom_range(0, 40),
            $urandom_range(0, 15), $urandom_range(0, 15), $urandom_range(0, 7));
      load();
      for (int k = 0; k < 25; k++)
        step($urandom_range(0, 45), $urandom_range(0, 17), 1'b0, "R6");
      wr($urandom_range(0, 3), $urandom_range(0, 4), $urandom_range(0, 40));
      for (int k = 0; k < 10; k++)
        step($urandom_range(0, 45), $urandom_range(0, 17), 1'b0, "R7");
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog pulse=%b expected=finish", pulse);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule